// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read path of a clocked DRAM-style memory. A requester presents a row, a starting column and a command on one clock edge. The block captures these in registers and then waits a fixed number of cycles while the row opens. After that wait it returns a run of words, one per clock, from consecutive columns of the same row. An internal column counter generates those addresses, so the requester gives only the first one.

The storage is a plain behavioural register array. It is loaded through the same command port with a single-word write command. A `ready` output shows when the sequencer can take a new command. Each returned word comes with a valid flag, and a one-cycle done pulse follows the last word of a burst. Both the row-open wait and the burst length are parameters.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ready` is 1 and `rd_valid` and `rd_done` are 0.
- R2: A command is taken only on a rising edge where `req_valid` and `ready` are both 1. A command presented while `ready` is 0 has no effect: it writes nothing and starts no burst.
- R3: For a read command (`req_write`=0) taken on edge k, the first word is on `rd_data` with `rd_valid`=1 in the cycle after edge k+LATENCY. With the defaults this is 4 cycles.
- R4: For each read, `rd_valid` is 1 for exactly BURST_LEN consecutive cycles (8 by default). It is 1 at no other time.
- R5: Word i of a burst (i = 0 .. BURST_LEN-1) is the stored word at row `req_row` and column (`req_col` + i) modulo 2^COL_W. The column wraps inside the row and never carries into the row.
- R6: `rd_done` is 1 for exactly one cycle, the cycle right after the last valid word. `ready` is 1 again in that same cycle. A read therefore occupies LATENCY+BURST_LEN cycles, which is 12 with the defaults.
- R7: A write command (`req_write`=1) taken on edge k stores `req_wdata` at {`req_row`,`req_col`}. `ready` is 0 only in the cycle after edge k. A read taken on the next edge returns the new value.
- R8: R3 to R6 hold for any LATENCY >= 2 and 1 <= BURST_LEN <= 2^COL_W.
- R9: From the cycle after a read is taken until the cycle in which `rd_done` is 1, `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A command is presented |
| req_write | input | 1 | 1 = single-word write, 0 = burst read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address (start column for reads) |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | A command can be taken on the next edge |
| rd_valid | output | 1 | `rd_data` holds a burst word |
| rd_data | output | DATA_W | Registered burst word |
| rd_done | output | 1 | One-cycle pulse after the last word of a burst |

## Verification
A read taken on edge k has fixed due dates. Word i is due in the cycle after edge k+LATENCY+i. The done pulse, together with the return of `ready`, is due one cycle after the last word. After a write, `ready` is due low for exactly one cycle. When the bench drives a command, it records the accepting edge. It then pushes each expected word and the done pulse, each tagged with its exact due cycle. A monitor samples at the falling edge and compares value and cycle. It reports any word or pulse that arrives early, late, twice or not at all. Three parameter settings run side by side. They cover wrap at the row end, a burst shorter than the row, the shortest allowed wait, and commands sent while busy.

// File: rtl/burst_pkg.sv
// Shared types for the burst read sequencer.
package burst_pkg;

    // Sequencer phases: idle, single write, row-open wait, word fetch, done slot.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_OPEN  = 3'd2,
        ST_BURST = 3'd3,
        ST_DRAIN = 3'd4
    } seq_state_t;

endpackage

// File: rtl/burst_cmd_regs.sv
// Command capture registers.
// Holds the row, column and write data of the last accepted command.
// Assumes: accept is high for exactly the edges that take a command.
module burst_cmd_regs #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Capture the command fields on an accepted command only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            row_q   <= row_in;
            col_q   <= col_in;
            wdata_q <= wdata_in;
        end
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
// Sequencer control.
// Takes one command at a time. A write goes through a single write slot.
// A read waits LATENCY-1 cycles in the row-open phase, then fetches
// BURST_LEN words, then spends one cycle in the done slot.
// Assumes: LATENCY >= 2 and BURST_LEN >= 1.
module burst_seq_ctrl
    import burst_pkg::*;
#(
    parameter int LATENCY   = 4,
    parameter int BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic ready,
    output logic accept,
    output logic wr_strobe,
    output logic fetch,
    output logic last_beat
);

    localparam int LAT_W  = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [LAT_W-1:0]  LAT_INIT  = LAT_W'(LATENCY - 2);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

    seq_state_t        state;
    logic [LAT_W-1:0]  lat_cnt;
    logic [BEAT_W-1:0] beat_cnt;

    // Decode the phase into handshake and strobe outputs.
    always_comb begin
        ready     = (state == ST_IDLE);
        accept    = ready && req_valid;
        wr_strobe = (state == ST_WRITE);
        fetch     = (state == ST_BURST);
        last_beat = fetch && (beat_cnt == BEAT_LAST);
    end

    // Phase register with the row-open countdown and the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_cnt  <= '0;
            beat_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_write) begin
                            state <= ST_WRITE;
                        end else begin
                            state   <= ST_OPEN;
                            lat_cnt <= LAT_INIT;
                        end
                    end
                end
                ST_WRITE: state <= ST_IDLE;
                ST_OPEN: begin
                    if (lat_cnt == '0) begin
                        state    <= ST_BURST;
                        beat_cnt <= '0;
                    end else begin
                        lat_cnt <= lat_cnt - LAT_W'(1);
                    end
                end
                ST_BURST: begin
                    if (beat_cnt == BEAT_LAST) begin
                        state <= ST_DRAIN;
                    end else begin
                        beat_cnt <= beat_cnt + BEAT_W'(1);
                    end
                end
                ST_DRAIN: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R7: the write slot lasts one cycle.
    p_write_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> (state == ST_IDLE));

    // R3: fetching starts only out of an expired row-open wait.
    p_burst_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch) |-> ($past(state) == ST_OPEN && $past(lat_cnt) == '0));

endmodule

// File: rtl/burst_col_counter.sv
// Column address counter.
// Loads the start column when a command is taken and advances by one on
// every fetch cycle. It wraps modulo 2^COL_W, so it stays inside the row.
// Assumes: load and advance are never high together.
module burst_col_counter #(
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] start_col,
    input  logic             advance,
    output logic [COL_W-1:0] col
);

    // Load on accept, otherwise step while fetching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
        end else if (load) begin
            col <= start_col;
        end else if (advance) begin
            col <= col + COL_W'(1);
        end
    end

    // R5: each fetch moves to the next column, wrapping inside the row.
    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (col == COL_W'($past(col) + COL_W'(1))));

endmodule

// File: rtl/burst_store.sv
// Behavioural storage array.
// One synchronous write port and one combinational read port; the read
// result is registered downstream. Contents are not reset.
module burst_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Present the addressed word to the output stage.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/burst_out_stage.sv
// Output registers.
// Registers each fetched word together with its valid flag, and delays the
// last-beat marker by one extra cycle to form the done pulse.
// Assumes: fetch is high for one unbroken run per burst.
module burst_out_stage #(
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic              last_beat,
    input  logic [DATA_W-1:0] word_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    localparam int RUN_W = $clog2(BURST_LEN + 1) + 1;

    logic last_q;

    // Register the word and its valid flag; hold the data between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= fetch;
            if (fetch) begin
                rd_data <= word_in;
            end
        end
    end

    // Turn the last-beat marker into a pulse one cycle after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            last_q  <= last_beat;
            rd_done <= last_q;
        end
    end

    // Checker support: length of the current run of valid words.
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (rd_valid) begin
            run_len <= run_len + RUN_W'(1);
        end else begin
            run_len <= '0;
        end
    end

    // R6: done comes right after the last word, and not together with a word.
    p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> ($past(rd_valid) && !rd_valid));

    // R4: the run that ends in a done pulse is exactly BURST_LEN long.
    p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (run_len == RUN_W'(BURST_LEN)));

    // R4: no run of valid words exceeds BURST_LEN.
    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUN_W'(BURST_LEN));

endmodule

// File: rtl/burst_read_seq.sv
// Synchronous burst read sequencer, top level.
// Captures one command at a time. Writes store a single word. Reads wait
// out a fixed row-open latency and then return BURST_LEN words from
// consecutive columns of one row, one per clock, with a done pulse after.
// Assumes: LATENCY >= 2, 1 <= BURST_LEN <= 2**COL_W.
module burst_read_seq #(
    parameter int ROW_W     = 3,
    parameter int COL_W     = 3,
    parameter int DATA_W    = 32,
    parameter int LATENCY   = 4,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    localparam int ADDR_W = ROW_W + COL_W;

    logic              accept;
    logic              wr_strobe;
    logic              fetch;
    logic              last_beat;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] wdata_q;
    logic [COL_W-1:0]  col_cnt;
    logic [DATA_W-1:0] word;

    burst_seq_ctrl #(
        .LATENCY   (LATENCY),
        .BURST_LEN (BURST_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .ready     (ready),
        .accept    (accept),
        .wr_strobe (wr_strobe),
        .fetch     (fetch),
        .last_beat (last_beat)
    );

    burst_cmd_regs #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .row_in   (req_row),
        .col_in   (req_col),
        .wdata_in (req_wdata),
        .row_q    (row_q),
        .col_q    (col_q),
        .wdata_q  (wdata_q)
    );

    burst_col_counter #(
        .COL_W (COL_W)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .start_col (req_col),
        .advance   (fetch),
        .col       (col_cnt)
    );

    burst_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_strobe),
        .wr_addr ({row_q, col_q}),
        .wr_data (wdata_q),
        .rd_addr ({row_q, col_cnt}),
        .rd_data (word)
    );

    burst_out_stage #(
        .DATA_W    (DATA_W),
        .BURST_LEN (BURST_LEN)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (fetch),
        .last_beat (last_beat),
        .word_in   (word),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_done   (rd_done)
    );

    // R9: while the sequencer is free, no burst word is on the output.
    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rd_valid);

    // R2: a command taken on an edge leaves the sequencer busy after it.
    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

endmodule

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps

// One DUT with a scoreboard. Each read pushes the words and the done
// pulse it expects, each with its due cycle; a monitor pops and compares.
module burst_harness #(
    parameter int LAT    = 4,
    parameter int BURSTN = 8
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_checks,
    output int   n_fails,
    output logic finished
);

    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int COLS  = 1 << COL_W;
    localparam int ROWS  = 1 << ROW_W;

    logic              req_valid;
    logic              req_write;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic [31:0]       req_wdata;
    logic              ready;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              rd_done;

    burst_read_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(32),
        .LATENCY(LAT), .BURST_LEN(BURSTN)
    ) i_burst_read_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done)
    );

    typedef struct {
        logic [31:0] data;
        int          cyc;
        int          idx;
        string       tag;
    } beat_t;

    beat_t       wq[$];
    int          dq[$];
    logic [31:0] shadow [ROWS*COLS];
    int          cyc = 0;
    int          d_checks = 0, d_fails = 0, m_checks = 0, m_fails = 0;

    assign n_checks = d_checks + m_checks;
    assign n_fails  = d_fails + m_fails;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pat(input int r, input int c);
        return 32'h5A00_0000 ^ (r << 12) ^ (c << 4) ^ (LAT << 20) ^ (BURSTN << 24);
    endfunction

    task automatic d_check(input bit ok, input string tag, input int act, input int exp);
        d_checks++;
        if (!ok) begin
            d_fails++;
            $display("FAIL %s L=%0d B=%0d actual=%0h expected=%0h", tag, LAT, BURSTN, act, exp);
        end
    endtask

    task automatic do_write(input int r, input int c, input logic [31:0] v);
        while (!ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_row = r[ROW_W-1:0]; req_col = c[COL_W-1:0]; req_wdata = v;
        shadow[r*COLS + c] = v;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        d_check(ready == 1'b0, "R7 busy after write", ready, 0);
        @(negedge clk);
        d_check(ready == 1'b1, "R7 free again", ready, 1);
    endtask

    // spam: send junk commands while busy (R2); tag marks the expected words.
    task automatic do_read(input int r, input int c, input bit spam, input string tag);
        int k;
        while (!ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_row = r[ROW_W-1:0]; req_col = c[COL_W-1:0];
        k = cyc + 1;
        for (int i = 0; i < BURSTN; i++) begin
            beat_t b;
            b.data = shadow[r*COLS + ((c + i) % COLS)];
            b.cyc  = k + LAT + i;
            b.idx  = i;
            b.tag  = tag;
            wq.push_back(b);
        end
        dq.push_back(k + LAT + BURSTN);
        @(negedge clk);
        req_valid = 0;
        d_check(ready == 1'b0, "R9 busy after read", ready, 0);
        if (spam) begin
            req_valid = 1; req_write = 1; req_row = 0; req_col = 0; req_wdata = 32'hDEAD_BEEF;
            for (int j = 0; j < LAT; j++) begin
                @(negedge clk);
                d_check(ready == 1'b0, "R9 busy during burst", ready, 0);
                req_write = (j % 2 == 0);
            end
            req_valid = 0; req_write = 0;
        end
    endtask

    // Monitor: compare each word and done pulse with its due cycle.
    always @(negedge clk) begin
        beat_t e;
        if (rst_n) begin
            if (rd_valid) begin
                m_checks++;
                if (wq.size() == 0) begin
                    m_fails++;
                    $display("FAIL R4 extra word L=%0d B=%0d actual=%0h expected=none", LAT, BURSTN, rd_data);
                end else begin
                    e = wq.pop_front();
                    if (cyc != e.cyc) begin
                        m_fails++;
                        $display("FAIL %s word %0d cycle L=%0d B=%0d actual=%0d expected=%0d",
                                 (e.idx == 0) ? "R3" : "R4", e.idx, LAT, BURSTN, cyc, e.cyc);
                    end
                    m_checks++;
                    if (rd_data != e.data) begin
                        m_fails++;
                        $display("FAIL %s word %0d data L=%0d B=%0d actual=%0h expected=%0h",
                                 e.tag, e.idx, LAT, BURSTN, rd_data, e.data);
                    end
                end
            end else if (wq.size() != 0 && wq[0].cyc <= cyc) begin
                m_checks++;
                m_fails++;
                $display("FAIL R4 missing word %0d L=%0d B=%0d actual=none expected=%0d",
                         wq[0].idx, LAT, BURSTN, wq[0].cyc);
                void'(wq.pop_front());
            end
            if (rd_done) begin
                m_checks++;
                if (dq.size() == 0 || dq[0] != cyc) begin
                    m_fails++;
                    $display("FAIL R6 R8 done cycle L=%0d B=%0d actual=%0d expected=%0d",
                             LAT, BURSTN, cyc, (dq.size() != 0) ? dq[0] : -1);
                end
                if (dq.size() != 0) void'(dq.pop_front());
                m_checks++;
                if (!ready) begin
                    m_fails++;
                    $display("FAIL R6 ready with done L=%0d B=%0d actual=%0d expected=1", LAT, BURSTN, ready);
                end
            end else if (dq.size() != 0 && dq[0] <= cyc) begin
                m_checks++;
                m_fails++;
                $display("FAIL R6 missing done L=%0d B=%0d actual=none expected=%0d", LAT, BURSTN, dq[0]);
                void'(dq.pop_front());
            end
        end
    end

    initial begin
        finished  = 0;
        req_valid = 0; req_write = 0; req_row = '0; req_col = '0; req_wdata = '0;
        @(negedge clk);
        // R1: state during reset.
        d_check(ready == 1'b1, "R1 ready in reset", ready, 1);
        d_check(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
        wait (rst_n == 1'b1);
        @(negedge clk);
        d_check(ready == 1'b1, "R1 ready after reset", ready, 1);
        d_check(rd_valid == 1'b0, "R1 valid after reset", rd_valid, 0);
        d_check(rd_done == 1'b0, "R1 done after reset", rd_done, 0);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                do_write(r, c, pat(r, c));
        do_read(0, 0, 0, "R5 R8");
        do_read(3, 5, 1, "R5 R8");            // wraps at the row end; junk sent while busy
        do_read(7, COLS - 1, 0, "R5 R8");
        do_read(2, COLS - 2, 0, "R5 R8");
        do_write(4, 3, 32'h0BAD_F00D);
        do_read(4, 3, 0, "R7 R5");            // read right after a write
        do_read(0, 0, 0, "R2 R5");            // junk write to (0,0) must not have landed
        while (wq.size() != 0 || dq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        finished = 1;
    end

endmodule

module test_burst_read_seq;

    logic clk = 0;
    logic rst_n = 0;
    int   c0, c1, c2, f0, f1, f2;
    logic d0, d1, d2;

    always #2.5 clk = ~clk;

    burst_harness #(.LAT(4), .BURSTN(8)) h_dflt  (.clk(clk), .rst_n(rst_n), .n_checks(c0), .n_fails(f0), .finished(d0));
    burst_harness #(.LAT(2), .BURSTN(3)) h_short (.clk(clk), .rst_n(rst_n), .n_checks(c1), .n_fails(f1), .finished(d1));
    burst_harness #(.LAT(6), .BURSTN(5)) h_long  (.clk(clk), .rst_n(rst_n), .n_checks(c2), .n_fails(f2), .finished(d2));

    initial begin
        int waited = 0;
        int checks, fails;
        repeat (4) @(negedge clk);
        rst_n = 1;
        while (!(d0 && d1 && d2) && waited < 50000) begin
            @(negedge clk);
            waited++;
        end
        checks = c0 + c1 + c2;
        fails  = f0 + f1 + f2;
        if (!(d0 && d1 && d2)) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", waited);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule